// File: doc/BRIEF.md
# Write-One-to-Clear Interrupt Controller

This block gathers four device event sources (data ready, status valid, locality change and command ready) into a 32-bit pending register. The host clears pending bits by writing ones to them. A per-source enable register, topped by a master gate bit, decides which pending bits may reach a single interrupt line. That line can signal in one of four ways: active-high level, active-low level, a rising pulse or a falling pulse. A `sig_mode` input selects the way, and a read-only capability word advertises all four.

The host reaches the block through a simple register port: a write strobe, a byte address, a write word, and a read word that follows the address combinationally. The port decodes four registers. Offset 0x08 is the enable register, 0x0C the byte-wide interrupt line number, 0x10 the pending register and 0x14 the capability word. Event generation lives outside the block. The sources arrive as one-cycle pulses on `src_evt`.

Top module: `irq_w1c_ctl`

## Requirements
- R1: After a synchronous active-low reset, the enable and pending registers read 0, the line-number register reads `VEC_RESET`, and `irq_o` sits at its idle level (low in mode 0 or 2, high in mode 1 or 3).
- R2: A pulse on `src_evt[0]`, `[1]`, `[2]` or `[3]` sets pending bit 0, 1, 2 or 7 respectively. The bit reads set from the cycle after the pulse, whatever the enables hold.
- R3: A write to offset 0x10 clears every pending bit whose write-data bit is 1 and leaves the others unchanged, so writing back the value just read clears everything pending.
- R4: When a source pulse and a clearing write hit the same pending bit in the same cycle, the bit stays set.
- R5: The enable register at 0x08 stores write-data bits 0, 1, 2, 7 and 31 and reads 0 in every other bit. It changes only when written.
- R6: While enable bit 31 (the master gate) is 0, `irq_o` stays at its idle level whatever is pending.
- R7: A source is active when both its pending bit and its enable bit are 1, and the master gate is 1. In mode 0, `irq_o` is high exactly while at least one source is active. In mode 1, `irq_o` is low exactly during those cycles.
- R8: In mode 2, `irq_o` is high for exactly one cycle, the first cycle in which the active set becomes non-empty. In mode 3, it is low for that one cycle instead and high otherwise.
- R9: The line-number register at 0x0C stores write-data bits 7:0, reads 0 in bits 31:8, and changes only when written.
- R10: The capability word at 0x14 reads 0x000000F8 plus bit 8 set when `STATIC_BURST` is 1. Bits 3, 4, 5 and 6 stand for level-high, level-low, rising and falling, and bit 7 for command-ready support. The default value is therefore 0x1F8.
- R11: Writes to 0x14 and to any undecoded offset change nothing. Reads of undecoded offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| src_evt | input | 4 | Event pulses: data ready, status valid, locality change, command ready |
| sig_mode | input | 2 | Line signalling: 0 level-high, 1 level-low, 2 rising pulse, 3 falling pulse |
| irq_o | output | 1 | Interrupt line |

## Verification
Every register update, including pending set, pending clear and enable or line-number writes, is visible on `bus_rdata` and `irq_o` one cycle after the stimulus edge. The line itself has no added register stage, and an edge-mode pulse lasts exactly from that edge to the next. The bench therefore applies stimulus just after a rising edge, advances its model at the following edge, and samples both outputs one time unit later. At that point it compares them with values the model derives from the requirements, including the edge-detect history the model keeps. Random traffic in all four modes is mixed with directed cases for reserved bits, the same-cycle set/clear race and the master gate.

// File: rtl/irq_ctl_pkg.sv
// Shared constants for the write-one-to-clear interrupt controller:
// register offsets, pending-bit placement of each source and line modes.
package irq_ctl_pkg;
    localparam int SRC_N = 4;
    // Bit position of each source in the pending and enable words.
    localparam int unsigned SRC_POS [SRC_N] = '{0, 1, 2, 7};
    localparam int unsigned GATE_POS = 31;

    localparam logic [7:0] OFS_ENABLE = 8'h08;
    localparam logic [7:0] OFS_VECTOR = 8'h0C;
    localparam logic [7:0] OFS_STATUS = 8'h10;
    localparam logic [7:0] OFS_CAPS   = 8'h14;

    typedef enum logic [1:0] {
        SIG_LVL_HI    = 2'd0,
        SIG_LVL_LO    = 2'd1,
        SIG_EDGE_RISE = 2'd2,
        SIG_EDGE_FALL = 2'd3
    } sig_mode_e;
endpackage

// File: rtl/irq_w1c_status.sv
// Pending register: one sticky bit per source, set by a source pulse and
// cleared by a write-one-to-clear strobe. A pulse wins over a clear.
// Assumes: src_evt pulses are synchronous to clk.
module irq_w1c_status
    import irq_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_we,
    input  logic [SRC_N-1:0]  clr_sel,
    input  logic [SRC_N-1:0]  src_evt,
    output logic [SRC_N-1:0]  pend_o,
    output logic [DATA_W-1:0] status_o
);
    logic [SRC_N-1:0] pend_q;

    // Set on a pulse, otherwise drop when selected by a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= src_evt | (pend_q & ~({SRC_N{clr_we}} & clr_sel));
    end

    // Place each pending bit at its register position.
    always_comb begin
        status_o = '0;
        for (int i = 0; i < SRC_N; i++) status_o[SRC_POS[i]] = pend_q[i];
    end

    assign pend_o = pend_q;

    for (genvar g = 0; g < SRC_N; g++) begin : g_chk
        // R2
        evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            src_evt[g] |=> pend_o[g]);
        // R3
        clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_sel[g] && !src_evt[g]) |=> !pend_o[g]);
        // R4
        evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_sel[g] && src_evt[g]) |=> pend_o[g]);
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Register decode: enable word with master gate, byte-wide line number,
// clear strobe for the pending word, capability constant and read mux.
// Assumes: bus_addr holds a byte offset; reads are side-effect free.
module irq_cfg_regs
    import irq_ctl_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         DATA_W       = 32,
    parameter int         VEC_W        = 8,
    parameter logic [7:0] VEC_RESET    = 8'h00,
    parameter bit         STATIC_BURST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] status_i,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [SRC_N-1:0]  en_o,
    output logic              gate_o,
    output logic              clr_we_o,
    output logic [SRC_N-1:0]  clr_sel_o
);
    localparam logic [DATA_W-1:0] CAP_WORD =
        DATA_W'(32'h0000_00F8) | (DATA_W'(STATIC_BURST) << 8);

    logic [SRC_N-1:0] en_q;
    logic             gate_q;
    logic [VEC_W-1:0] vec_q;
    logic [SRC_N-1:0] wsel;
    logic             hit_en, hit_vec;

    // Gather the write-data bits that sit at each source position.
    always_comb begin
        for (int i = 0; i < SRC_N; i++) wsel[i] = bus_wdata[SRC_POS[i]];
    end

    assign hit_en    = bus_wr && (bus_addr == ADDR_W'(OFS_ENABLE));
    assign hit_vec   = bus_wr && (bus_addr == ADDR_W'(OFS_VECTOR));
    assign clr_we_o  = bus_wr && (bus_addr == ADDR_W'(OFS_STATUS));
    assign clr_sel_o = wsel;

    // Enable word and master gate, written as a whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            gate_q <= 1'b0;
        end else if (hit_en) begin
            en_q   <= wsel;
            gate_q <= bus_wdata[GATE_POS];
        end
    end

    // Line-number byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       vec_q <= VEC_W'(VEC_RESET);
        else if (hit_vec) vec_q <= bus_wdata[VEC_W-1:0];
    end

    // Read multiplexer; undecoded offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_ENABLE): begin
                for (int i = 0; i < SRC_N; i++) bus_rdata[SRC_POS[i]] = en_q[i];
                bus_rdata[GATE_POS] = gate_q;
            end
            ADDR_W'(OFS_VECTOR): bus_rdata[VEC_W-1:0] = vec_q;
            ADDR_W'(OFS_STATUS): bus_rdata = status_i;
            ADDR_W'(OFS_CAPS):   bus_rdata = CAP_WORD;
            default:             bus_rdata = '0;
        endcase
    end

    assign en_o   = en_q;
    assign gate_o = gate_q;

    // R5
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_ENABLE)) |=> ($stable(en_o) && $stable(gate_o)));
    // R9
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(OFS_VECTOR)) |=> $stable(vec_q));
endmodule

// File: rtl/irq_line_drv.sv
// Line driver: turns the "some source active" flag into the selected
// level or single-cycle pulse form.
// Assumes: sig_mode is changed only while no interrupt is expected.
module irq_line_drv
    import irq_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic [1:0] mode_i,
    output logic       irq_o
);
    logic      active_d;
    logic      rise;
    sig_mode_e mode;

    // Remember last cycle's active flag for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_d <= 1'b0;
        else        active_d <= active_i;
    end

    assign rise = active_i & ~active_d;
    assign mode = sig_mode_e'(mode_i);

    // Shape the line according to the selected signalling mode.
    always_comb begin
        case (mode)
            SIG_LVL_HI:    irq_o = active_i;
            SIG_LVL_LO:    irq_o = ~active_i;
            SIG_EDGE_RISE: irq_o = rise;
            default:       irq_o = ~rise;
        endcase
    end

    // R8
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SIG_EDGE_RISE && irq_o) |=> (mode_i != 2'd2 || !irq_o));
    // R8
    fall_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SIG_EDGE_FALL && !irq_o) |=> (mode_i != 2'd3 || irq_o));
endmodule

// File: rtl/irq_w1c_ctl.sv
// Top of the write-one-to-clear interrupt controller: pending register,
// configuration registers and line driver. A source is active when it is
// pending, enabled and the master gate is set.
// Assumes: single clock domain, synchronous active-low reset.
module irq_w1c_ctl
    import irq_ctl_pkg::*;
#(
    parameter int         ADDR_W       = 8,
    parameter int         DATA_W       = 32,
    parameter int         VEC_W        = 8,
    parameter logic [7:0] VEC_RESET    = 8'h00,
    parameter bit         STATIC_BURST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [3:0]        src_evt,
    input  logic [1:0]        sig_mode,
    output logic              irq_o
);
    logic [SRC_N-1:0]  pend, en, clr_sel;
    logic [DATA_W-1:0] status_word;
    logic              gate, clr_we, active;

    irq_w1c_status #(.DATA_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .clr_we(clr_we), .clr_sel(clr_sel),
        .src_evt(src_evt), .pend_o(pend), .status_o(status_word)
    );

    irq_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
        .VEC_RESET(VEC_RESET), .STATIC_BURST(STATIC_BURST)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status_i(status_word), .bus_rdata(bus_rdata),
        .en_o(en), .gate_o(gate), .clr_we_o(clr_we), .clr_sel_o(clr_sel)
    );

    // Any enabled pending source behind the master gate.
    assign active = gate & |(pend & en);

    irq_line_drv u_line (
        .clk(clk), .rst_n(rst_n), .active_i(active), .mode_i(sig_mode),
        .irq_o(irq_o)
    );

    // R6
    gate_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gate |-> (irq_o == (sig_mode == 2'd1 || sig_mode == 2'd3)));
endmodule

// File: tb/irq_w1c_ctl_tb.sv
`timescale 1ns/1ps
module irq_w1c_ctl_tb_top;
    localparam logic [31:0] EN_MASK = 32'h8000_0087;
    localparam logic [31:0] ST_MASK = 32'h0000_0087;
    localparam logic [31:0] CAP_EXP = 32'h0000_01F8;
    localparam logic [7:0]  VEC_RST = 8'h00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  src_evt = '0;
    logic [1:0]  sig_mode = 2'd0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_stat, m_en;
    logic [7:0]  m_vec;
    bit          m_act, m_prev;

    always #2.5 clk = ~clk;

    irq_w1c_ctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_evt(src_evt),
        .sig_mode(sig_mode), .irq_o(irq_o)
    );

    function automatic logic [31:0] evt_word(logic [3:0] e);
        return {24'd0, e[3], 4'd0, e[2], e[1], e[0]};
    endfunction

    function automatic bit act_of(logic [31:0] st, logic [31:0] en);
        return en[31] && ((st & en & ST_MASK) != 0);
    endfunction

    function automatic bit irq_exp(logic [1:0] m, bit a, bit p);
        case (m)
            2'd0:    return a;
            2'd1:    return !a;
            2'd2:    return a && !p;
            default: return !(a && !p);
        endcase
    endfunction

    function automatic logic [31:0] rd_exp(logic [7:0] a);
        case (a)
            8'h08:   return m_en;
            8'h0C:   return {24'd0, m_vec};
            8'h10:   return m_stat;
            8'h14:   return CAP_EXP;
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_stat = '0; m_en = '0; m_vec = VEC_RST; m_act = 0; m_prev = 0;
    endtask

    // One clock: apply stimulus, advance the model at the edge, check irq.
    task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d, logic [3:0] e, string tag);
        bus_wr = wr; bus_addr = a; bus_wdata = d; src_evt = e;
        @(posedge clk); #1;
        m_prev = m_act;
        m_stat = ((m_stat & ~((wr && a == 8'h10) ? d : 32'd0)) | evt_word(e)) & ST_MASK;
        if (wr && a == 8'h08) m_en  = d & EN_MASK;
        if (wr && a == 8'h0C) m_vec = d[7:0];
        m_act = act_of(m_stat, m_en);
        bus_wr = 0; src_evt = '0;
        chk(tag, {31'd0, irq_o}, {31'd0, irq_exp(sig_mode, m_act, m_prev)});
    endtask

    task automatic rd(logic [7:0] a, string tag);
        bus_addr = a; #0.2;
        chk(tag, bus_rdata, rd_exp(a));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h08, "R1 enable"); chk("R1 enable lit", bus_rdata, 32'd0);
        rd(8'h10, "R1 status"); chk("R1 status lit", bus_rdata, 32'd0);
        rd(8'h0C, "R1 vector");
        chk("R1 irq idle", {31'd0, irq_o}, 32'd0);
        // R10 capability, R11 ignored writes
        rd(8'h14, "R10 caps"); chk("R10 caps lit", bus_rdata, 32'h1F8);
        cyc(1, 8'h14, 32'hFFFF_FFFF, 4'h0, "R11 caps write irq");
        rd(8'h14, "R11 caps after write");
        cyc(1, 8'h20, 32'hFFFF_FFFF, 4'h0, "R11 undecoded write irq");
        rd(8'h20, "R11 undecoded read"); rd(8'h08, "R11 enable untouched");
        // R9 vector
        cyc(1, 8'h0C, 32'hFFFF_FF5A, 4'h0, "R9 vec write irq");
        rd(8'h0C, "R9 vec"); chk("R9 vec lit", bus_rdata, 32'h5A);
        // R5 enable masking
        cyc(1, 8'h08, 32'hFFFF_FFFF, 4'h0, "R5 en write irq");
        rd(8'h08, "R5 en"); chk("R5 en lit", bus_rdata, 32'h8000_0087);
        // R2 events set status with enables clear
        cyc(1, 8'h08, 32'h0, 4'h0, "R2 en clear irq");
        cyc(0, 8'h10, 32'h0, 4'hF, "R2 evt irq stays idle");
        rd(8'h10, "R2 status"); chk("R2 status lit", bus_rdata, 32'h87);
        // R3 write back clears all
        cyc(1, 8'h10, 32'h87, 4'h0, "R3 clear irq");
        rd(8'h10, "R3 status cleared"); chk("R3 lit", bus_rdata, 32'h0);
        cyc(0, 8'h10, 32'h0, 4'h6, "R3 partial setup");
        cyc(1, 8'h10, 32'h4, 4'h0, "R3 partial clear");
        rd(8'h10, "R3 partial"); chk("R3 partial lit", bus_rdata, 32'h2);
        // R4 event wins over same-cycle clear
        cyc(1, 8'h10, 32'h83, 4'h1, "R4 race irq");
        rd(8'h10, "R4 status"); chk("R4 lit", bus_rdata, 32'h1);
        // R6 master gate
        cyc(1, 8'h08, 32'h87, 4'h0, "R6 gate off irq idle");
        chk("R6 gate off lit", {31'd0, irq_o}, 32'd0);
        cyc(1, 8'h08, 32'h8000_0001, 4'h0, "R7 gate on level high");
        chk("R7 level lit", {31'd0, irq_o}, 32'd1);
        // R8 directed rising and falling pulses
        cyc(1, 8'h10, 32'hFF, 4'h0, "R7 level drop");
        sig_mode = 2'd2;
        cyc(0, 8'h00, 32'h0, 4'h1, "R8 rise pulse");
        chk("R8 rise lit", {31'd0, irq_o}, 32'd1);
        cyc(0, 8'h00, 32'h0, 4'h0, "R8 rise end");
        chk("R8 rise end lit", {31'd0, irq_o}, 32'd0);
        cyc(1, 8'h10, 32'hFF, 4'h0, "R8 clear");
        sig_mode = 2'd3;
        cyc(0, 8'h00, 32'h0, 4'h1, "R8 fall pulse");
        chk("R8 fall lit", {31'd0, irq_o}, 32'd0);
        cyc(0, 8'h00, 32'h0, 4'h0, "R8 fall end");
        chk("R8 fall end lit", {31'd0, irq_o}, 32'd1);
        // Random traffic in every mode (R2 R3 R5 R7 R8 R9)
        for (int m = 0; m < 4; m++) begin
            sig_mode = 2'(m);
            cyc(1, 8'h10, 32'hFFFF_FFFF, 4'h0, "R7 R8 mode entry");
            for (int k = 0; k < 600; k++) begin
                logic [7:0]  a;
                logic [31:0] d;
                logic [3:0]  e;
                bit          w;
                case ($urandom % 6)
                    0: a = 8'h08; 1: a = 8'h0C; 2: a = 8'h10;
                    3: a = 8'h14; 4: a = 8'h00; default: a = 8'h10;
                endcase
                w = ($urandom % 3) == 0;
                d = $urandom;
                if (a == 8'h08 && ($urandom % 4) != 0) d[31] = 1'b1;
                e = (($urandom % 6) == 0) ? 4'($urandom) : 4'h0;
                cyc(w, a, d, e, (m < 2) ? "R7 random irq" : "R8 random irq");
                rd(8'($urandom % 2 == 0 ? 8'h10 : a), "R2 R3 R5 R9 random read");
            end
        end
        // R1 reset again mid-traffic
        sig_mode = 2'd1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        model_reset();
        chk("R1 irq idle low mode", {31'd0, irq_o}, 32'd1);
        rd(8'h10, "R1 status after reset");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule